// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits on the host side of a synchronous DRAM. It turns one request at a time (mode load, activate, read, write, precharge, auto refresh, self refresh) into registered command cycles on the chip select, row strobe, column strobe, write enable, clock enable, bank and address pins. It keeps a table of which banks hold an open row and runs one spacing counter, so it holds a request until the request is legal and timely. When a mode load or refresh finds open rows, it first inserts a precharge of every bank.

Reads and writes are tracked after issue. A read-data valid strobe follows the programmed CAS latency and burst length. A write-data enable spans the write burst, or a single beat when the mode register asks for single-location writes. The byte mask pin is timed to the data of the access it belongs to: in the same cycle for writes, and two cycles before the data for reads. Only one access is in flight at a time. A request is accepted in the cycle where `reqReady` is high, and its command appears on the pins in the following cycle.

Top module: `sdram_cmd_seq`

## Requirements
- R1: During and right after reset the pins show deselect (csN=1). cke is 1, and rdValid, wrDataEn and dqm are 0. The mode register resets to CAS latency 3, burst length 1 and burst writes.
- R2: Every command drives csN=0, with {rasN,casN,weN} set as follows: activate 011, read 101, write 100, precharge 010, refresh 001, mode load 000. reqKind uses these codes: 0 nop, 1 mode load, 2 activate, 3 read, 4 write, 5 precharge, 6 auto refresh, 7 self refresh.
- R3: After reset, every cycle with no command shows NOP (csN=0, {rasN,casN,weN}=111).
- R4: A mode load drives addr[11:0] from reqAddr[11:0] with addr[12]=0 and ba=0. The mode fields are: bits [2:0] burst code (0,1,2,3 give 1,2,4,8 beats, anything else gives 1), bits [6:4] latency (2 gives latency 2, anything else gives 3) and bit 9 single-location writes.
- R5: After a mode load, the next command comes at least TMRD cycles later, and exactly TMRD cycles later when it is requested at once.
- R6: An activate drives addr=reqAddr and ba=reqBank. It is held while that bank is open. A read or write that follows at once appears exactly TRCD cycles after the activate.
- R7: A read or write drives addr[8:0] as the column, addr[10] as reqAutoPre and ba as reqBank. It is held while its bank is closed, and an auto-precharging access closes its bank.
- R8: A precharge with reqAutoPre=1 drives addr[10]=1 and ba=0 and closes every bank. With reqAutoPre=0 it drives addr[10]=0 and ba=reqBank and closes that bank only.
- R9: A mode load or refresh request that finds any bank open first causes a precharge-all. The request itself then appears exactly TRP cycles after that precharge.
- R10: Auto refresh drives the refresh code with cke=1. The next command comes exactly TRFC cycles later when it is requested at once.
- R11: Self refresh drives the refresh code with cke=0 in the same cycle, and cke stays 0 while every other request is held. A request of kind 0 then raises cke with a NOP, and the next command comes exactly TXSR cycles after the exit cycle.
- R12: rdValid is high for the burst length, starting exactly CL cycles after the read command cycle.
- R13: wrDataEn is high starting in the write command cycle. It lasts the burst length, or exactly one cycle when mode bit 9 is set.
- R14: dqm equals the request's reqMask in the write data cycles. For a read it is reqMask for burst-length cycles starting CL-2 cycles after the read command. In every other cycle dqm is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqKind | input | 3 | Request kind code (R2) |
| reqBank | input | BANK_W | Target bank |
| reqAddr | input | ADDR_W | Row, column or mode op-code |
| reqAutoPre | input | 1 | Auto precharge for read/write, all banks for precharge |
| reqMask | input | DM_W | Byte mask for the access |
| reqReady | output | 1 | Request accepted at this clock edge |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus |
| dqm | output | DM_W | Data mask |
| rdValid | output | 1 | Read data valid strobe |
| wrDataEn | output | 1 | Write data enable |

## Verification
The main function is swept over all sixteen mode settings, formed from two latencies, four burst codes and both write-burst settings, with a different bank, column and mask in each. This separates an off-by-one in the latency path from an error in the burst count, and separates the read mask lead from the zero-delay write mask. Further runs open two banks and close them by single-bank and by all-bank precharge, request accesses to closed banks, and ask for a mode load while a row is open. These show whether A10 and the bank pins are chosen correctly and whether the hidden precharge is inserted. Refresh and self-refresh runs check the clock-enable behaviour and the recovery spacing.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    REQ_NOP  = 3'd0,
    REQ_LMR  = 3'd1,
    REQ_ACT  = 3'd2,
    REQ_RD   = 3'd3,
    REQ_WR   = 3'd4,
    REQ_PRE  = 3'd5,
    REQ_REF  = 3'd6,
    REQ_SREF = 3'd7
  } req_e;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_RD    = 4'b0101,
    CMD_WR    = 4'b0100,
    CMD_PRE   = 4'b0010,
    CMD_REF   = 4'b0001,
    CMD_LMR   = 4'b0000
  } cmd_e;

  typedef struct packed {
    logic issue;    // a command goes onto the pins at the next edge
    cmd_e cmd;      // which one (NOP when issue is low)
    logic preAll;   // inserted precharge of every bank
    logic ckeLow;   // self refresh entry
    logic ckeHigh;  // self refresh exit
  } seq_strobe_t;

endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int TMRD   = 2,
  parameter int TRCD   = 2,
  parameter int TRP    = 2,
  parameter int TRFC   = 4,
  parameter int TXSR   = 4,
  parameter int GAP_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  req_e              reqKind,
  input  logic [BANK_W-1:0] reqBank,
  input  logic              reqAutoPre,
  input  logic              modeCl3,
  input  logic [3:0]        modeBurst,
  input  logic              modeWrSingle,
  output logic              reqReady,
  output seq_strobe_t       strobe
);

  localparam int NBANK = 1 << BANK_W;

  logic [NBANK-1:0] bankOpen;
  logic [GAP_W-1:0] gapCnt;
  logic             inSref;
  logic             accept;
  logic             insertPre;
  cmd_e             kindCmd;
  int unsigned      gapLen;
  logic [3:0]       wrLen;

  assign wrLen = modeWrSingle ? 4'd1 : modeBurst;

  always_comb begin
    accept    = 1'b0;
    insertPre = 1'b0;
    if (reqValid && gapCnt == '0) begin
      if (inSref) begin
        accept = (reqKind == REQ_NOP);
      end else begin
        case (reqKind)
          REQ_NOP, REQ_PRE:           accept = 1'b1;
          REQ_LMR, REQ_REF, REQ_SREF: begin
            if (|bankOpen) insertPre = 1'b1;
            else           accept    = 1'b1;
          end
          REQ_ACT:                    accept = !bankOpen[reqBank];
          REQ_RD, REQ_WR:             accept = bankOpen[reqBank];
          default:                    accept = 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    case (reqKind)
      REQ_LMR:            kindCmd = CMD_LMR;
      REQ_ACT:            kindCmd = CMD_ACT;
      REQ_RD:             kindCmd = CMD_RD;
      REQ_WR:             kindCmd = CMD_WR;
      REQ_PRE:            kindCmd = CMD_PRE;
      REQ_REF, REQ_SREF:  kindCmd = CMD_REF;
      default:            kindCmd = CMD_NOP;
    endcase
  end

  always_comb begin
    strobe.issue   = insertPre || (accept && !inSref && reqKind != REQ_NOP);
    strobe.cmd     = insertPre ? CMD_PRE : (strobe.issue ? kindCmd : CMD_NOP);
    strobe.preAll  = insertPre;
    strobe.ckeLow  = accept && !inSref && reqKind == REQ_SREF;
    strobe.ckeHigh = accept && inSref;
  end

  // Cycles until the next command may reach the pins.
  always_comb begin
    if (insertPre)   gapLen = TRP;
    else if (inSref) gapLen = TXSR;
    else begin
      case (reqKind)
        REQ_LMR: gapLen = TMRD;
        REQ_ACT: gapLen = TRCD;
        REQ_RD:  gapLen = (modeCl3 ? 3 : 2) + modeBurst + (reqAutoPre ? TRP : 0);
        REQ_WR:  gapLen = wrLen + (reqAutoPre ? TRP : 0);
        REQ_PRE: gapLen = TRP;
        REQ_REF: gapLen = TRFC;
        default: gapLen = 1;
      endcase
    end
  end

  assign reqReady = accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankOpen <= '0;
      gapCnt   <= '0;
      inSref   <= 1'b0;
    end else begin
      if (accept || insertPre)  gapCnt <= GAP_W'(gapLen - 1);
      else if (gapCnt != '0)    gapCnt <= gapCnt - 1'b1;

      if (insertPre) bankOpen <= '0;
      else if (accept && !inSref) begin
        case (reqKind)
          REQ_ACT:        bankOpen[reqBank] <= 1'b1;
          REQ_RD, REQ_WR: if (reqAutoPre) bankOpen[reqBank] <= 1'b0;
          REQ_PRE: begin
            if (reqAutoPre) bankOpen <= '0;
            else            bankOpen[reqBank] <= 1'b0;
          end
          default: ;
        endcase
      end

      if (strobe.ckeLow)       inSref <= 1'b1;
      else if (strobe.ckeHigh) inSref <= 1'b0;
    end
  end

  // R11: nothing is issued while the device sits in self refresh
  assert_no_cmd_in_sref_R11: assert property (@(posedge clk) disable iff (!rstN)
    inSref |-> !strobe.issue);

  // R4: mode load only with every bank idle
  assert_lmr_all_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.cmd == CMD_LMR) |-> bankOpen == '0);

  // R5: the cycle after a mode load carries no command (TMRD >= 2)
  assert_lmr_spacing_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.cmd == CMD_LMR) |=> !strobe.issue);

  // R6: activate only to an idle bank
  assert_act_idle_bank_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && strobe.cmd == CMD_ACT) |-> !bankOpen[reqBank]);

  // R7: column access only to an open bank
  assert_col_open_bank_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && (strobe.cmd == CMD_RD || strobe.cmd == CMD_WR)) |-> bankOpen[reqBank]);

endmodule

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int DM_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqAutoPre,
  input  logic [DM_W-1:0]   reqMask,
  output logic [3:0]        cmdPins,
  output logic              cke,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DM_W-1:0]   dqm,
  output logic              rdValid,
  output logic              wrDataEn,
  output logic              modeCl3,
  output logic [3:0]        modeBurst,
  output logic              modeWrSingle
);

  localparam int AP_BIT = 10;

  logic [2:0]        blField;
  logic [2:0]        clField;
  logic              wrSingle;
  logic [ADDR_W-1:0] nextAddr;
  logic [BANK_W-1:0] nextBank;
  logic              startRd, startWr;
  logic [2:0]        rdStart;
  logic [3:0]        rdRemain, wrRemain, dqmRemain;
  logic [DM_W-1:0]   dqmHeld;
  logic [3:0]        wrLen;
  logic              rdLoad, rdMaskLoad;

  assign modeCl3      = (clField != 3'd2);
  assign modeWrSingle = wrSingle;
  always_comb begin
    case (blField)
      3'd1:    modeBurst = 4'd2;
      3'd2:    modeBurst = 4'd4;
      3'd3:    modeBurst = 4'd8;
      default: modeBurst = 4'd1;
    endcase
  end
  assign wrLen = wrSingle ? 4'd1 : modeBurst;

  always_comb begin
    nextAddr = '0;
    nextBank = '0;
    case (strobe.cmd)
      CMD_LMR: nextAddr[11:0] = reqAddr[11:0];
      CMD_ACT: begin
        nextAddr = reqAddr;
        nextBank = reqBank;
      end
      CMD_RD, CMD_WR: begin
        nextAddr[COL_W-1:0] = reqAddr[COL_W-1:0];
        nextAddr[AP_BIT]    = reqAutoPre;
        nextBank            = reqBank;
      end
      CMD_PRE: begin
        if (strobe.preAll || reqAutoPre) nextAddr[AP_BIT] = 1'b1;
        else                             nextBank = reqBank;
      end
      default: ;
    endcase
  end

  assign startRd    = strobe.issue && strobe.cmd == CMD_RD;
  assign startWr    = strobe.issue && strobe.cmd == CMD_WR;
  assign rdLoad     = modeCl3 ? rdStart[2] : rdStart[1];
  assign rdMaskLoad = modeCl3 ? rdStart[0] : startRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPins  <= CMD_DESEL;
      cke      <= 1'b1;
      ba       <= '0;
      addr     <= '0;
      clField  <= 3'd3;
      blField  <= 3'd0;
      wrSingle <= 1'b0;
      rdStart  <= '0;
      rdRemain <= '0;
      wrRemain <= '0;
      dqmRemain <= '0;
      dqmHeld  <= '0;
    end else begin
      cmdPins <= strobe.cmd;
      if (strobe.issue) begin
        addr <= nextAddr;
        ba   <= nextBank;
      end
      if (strobe.ckeLow)       cke <= 1'b0;
      else if (strobe.ckeHigh) cke <= 1'b1;
      if (strobe.issue && strobe.cmd == CMD_LMR) begin
        blField  <= reqAddr[2:0];
        clField  <= reqAddr[6:4];
        wrSingle <= reqAddr[9];
      end
      rdStart <= {rdStart[1:0], startRd};
      if (rdLoad)               rdRemain <= modeBurst;
      else if (rdRemain != '0)  rdRemain <= rdRemain - 1'b1;
      if (startWr)              wrRemain <= wrLen;
      else if (wrRemain != '0)  wrRemain <= wrRemain - 1'b1;
      if (startWr)              dqmRemain <= wrLen;
      else if (rdMaskLoad)      dqmRemain <= modeBurst;
      else if (dqmRemain != '0) dqmRemain <= dqmRemain - 1'b1;
      if (startRd || startWr)   dqmHeld <= reqMask;
    end
  end

  assign rdValid  = (rdRemain != '0);
  assign wrDataEn = (wrRemain != '0);
  assign dqm      = (dqmRemain != '0) ? dqmHeld : '0;

  // R12/R13: read and write data windows never overlap
  assert_data_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && wrDataEn));

  // R11: clock enable drops only together with the refresh code
  assert_cke_fall_ref_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> cmdPins == CMD_REF);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int DM_W   = 2,
  parameter int TMRD   = 2,
  parameter int TRCD   = 2,
  parameter int TRP    = 2,
  parameter int TRFC   = 4,
  parameter int TXSR   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqAutoPre,
  input  logic [DM_W-1:0]   reqMask,
  output logic              reqReady,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DM_W-1:0]   dqm,
  output logic              rdValid,
  output logic              wrDataEn
);

  localparam int GAP_W = $clog2(TMRD + TRCD + TRP + TRFC + TXSR + 16);

  seq_strobe_t strobe;
  logic        modeCl3;
  logic [3:0]  modeBurst;
  logic        modeWrSingle;
  logic [3:0]  cmdPins;

  sdram_seq_ctrl #(
    .BANK_W(BANK_W), .TMRD(TMRD), .TRCD(TRCD), .TRP(TRP),
    .TRFC(TRFC), .TXSR(TXSR), .GAP_W(GAP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(req_e'(reqKind)),
    .reqBank(reqBank), .reqAutoPre(reqAutoPre), .modeCl3(modeCl3),
    .modeBurst(modeBurst), .modeWrSingle(modeWrSingle),
    .reqReady(reqReady), .strobe(strobe)
  );

  sdram_seq_dp #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .DM_W(DM_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqBank(reqBank),
    .reqAddr(reqAddr), .reqAutoPre(reqAutoPre), .reqMask(reqMask),
    .cmdPins(cmdPins), .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
    .rdValid(rdValid), .wrDataEn(wrDataEn), .modeCl3(modeCl3),
    .modeBurst(modeBurst), .modeWrSingle(modeWrSingle)
  );

  assign {csN, rasN, casN, weN} = cmdPins;

endmodule

// File: tb/sdram_cmd_seq_test.sv
`timescale 1ns/1ps
module sdram_cmd_seq_test;

  localparam int TMRD = 2, TRCD = 2, TRP = 2, TRFC = 4, TXSR = 4;
  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_PRE = 4'b0010, P_REF = 4'b0001,
                         P_LMR = 4'b0000;

  logic        clk = 0, rstN = 0;
  logic        reqValid = 0, reqAutoPre = 0;
  logic [2:0]  reqKind = 0;
  logic [1:0]  reqBank = 0, reqMask = 0;
  logic [12:0] reqAddr = 0;
  logic        reqReady, csN, rasN, casN, weN, cke, rdValid, wrDataEn;
  logic [1:0]  ba, dqm;
  logic [12:0] addr;
  logic [3:0]  pinCmd;
  int          cyc = 0, nChk = 0, nFail = 0, lastPreCyc = -1;
  logic        lastPreA10 = 0;
  bit          done = 0;

  sdram_cmd_seq #(.TMRD(TMRD), .TRCD(TRCD), .TRP(TRP), .TRFC(TRFC), .TXSR(TXSR)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqBank(reqBank),
    .reqAddr(reqAddr), .reqAutoPre(reqAutoPre), .reqMask(reqMask), .reqReady(reqReady),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .cke(cke), .ba(ba), .addr(addr),
    .dqm(dqm), .rdValid(rdValid), .wrDataEn(wrDataEn));

  assign pinCmd = {csN, rasN, casN, weN};
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (pinCmd == P_PRE) begin lastPreCyc = cyc; lastPreA10 = addr[10]; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReq(input logic [2:0] k, input logic [1:0] b, input logic [12:0] a,
                       input logic ap, input logic [1:0] m, output int pc);
    @(negedge clk);
    reqValid = 1; reqKind = k; reqBank = b; reqAddr = a; reqAutoPre = ap; reqMask = m;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    pc = cyc;
    reqValid = 0;
  endtask

  task automatic holdCheck(input logic [2:0] k, input logic [1:0] b, input int n, input string req);
    @(negedge clk);
    reqValid = 1; reqKind = k; reqBank = b; reqAutoPre = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      chk(reqReady == 0, req, int'(reqReady), 0);
      if (i > 0) chk(pinCmd == P_NOP, {req, " pins"}, int'(pinCmd), int'(P_NOP));
    end
    reqValid = 0;
  endtask

  task automatic pinCheck(input logic [3:0] ec, input logic [12:0] ea, input logic [1:0] eb,
                          input logic ecke, input string req);
    @(negedge clk);
    chk(pinCmd == ec, {req, " cmd"}, int'(pinCmd), int'(ec));
    chk(addr == ea, {req, " addr"}, int'(addr), int'(ea));
    chk(ba == eb, {req, " ba"}, int'(ba), int'(eb));
    chk(cke == ecke, {req, " cke"}, int'(cke), int'(ecke));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pinCmd == 4'b1111, "R1 deselect", int'(pinCmd), 15);
    chk(cke == 1, "R1 cke", int'(cke), 1);
    chk(rdValid == 0 && wrDataEn == 0 && dqm == 0, "R1 data", int'({rdValid, wrDataEn, dqm}), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(pinCmd == P_NOP, "R3 idle nop", int'(pinCmd), int'(P_NOP));

    // Sweep over every latency / burst / write mode setting
    for (int cfg = 0; cfg < 16; cfg++) begin
      int cl, bl, wl, blc;
      logic m9;
      logic [11:0] op;
      logic [1:0] bk, mk;
      logic [8:0] col;
      cl = (cfg & 1) ? 3 : 2;
      blc = (cfg >> 1) & 3;
      m9 = cfg[3];
      bl = 1 << blc;
      wl = m9 ? 1 : bl;
      bk = 2'(cfg);
      mk = 2'(cfg + 1);
      col = 9'(cfg * 37 + 5);
      op = {2'b0, m9, 2'b0, 3'(cl), 1'b0, 3'(blc)};
      doReq(3'd1, 2'd0, {1'b0, op}, 0, 0, t0);
      pinCheck(P_LMR, {1'b0, op}, 2'd0, 1, "R4 R2 mode load");
      doReq(3'd2, bk, 13'(cfg * 111 + 7), 0, 0, t1);
      chk(t1 - t0 == TMRD, "R5 tMRD", t1 - t0, TMRD);
      pinCheck(P_ACT, 13'(cfg * 111 + 7), bk, 1, "R6 R2 activate");
      doReq(3'd3, bk, {4'b0, col}, 0, mk, t2);
      chk(t2 - t1 == TRCD, "R6 tRCD", t2 - t1, TRCD);
      for (int k = 0; k < cl + bl + 3; k++) begin
        logic ev;
        logic [1:0] em;
        @(negedge clk);
        if (k == 0) begin
          chk(pinCmd == P_RD, "R2 read cmd", int'(pinCmd), int'(P_RD));
          chk(addr == {4'b0, col} && ba == bk, "R7 read addr", int'(addr), int'(col));
        end else chk(pinCmd == P_NOP, "R3 nop in read", int'(pinCmd), int'(P_NOP));
        ev = (k >= cl && k < cl + bl);
        em = (k >= cl - 2 && k < cl - 2 + bl) ? mk : 2'b0;
        chk(rdValid == ev, "R12 rdValid", int'(rdValid), int'(ev));
        chk(dqm == em, "R14 read dqm", int'(dqm), int'(em));
      end
      doReq(3'd4, bk, {4'b0, ~col}, 1, ~mk, t2);
      for (int k = 0; k < wl + 2; k++) begin
        logic ev;
        logic [1:0] em;
        @(negedge clk);
        if (k == 0) begin
          chk(pinCmd == P_WR, "R2 write cmd", int'(pinCmd), int'(P_WR));
          chk(addr == {4'b0010, ~col} && ba == bk, "R7 write addr a10", int'(addr), int'({4'b0010, ~col}));
        end
        ev = (k < wl);
        em = ev ? ~mk : 2'b0;
        chk(wrDataEn == ev, "R13 wrDataEn", int'(wrDataEn), int'(ev));
        chk(dqm == em, "R14 write dqm", int'(dqm), int'(em));
      end
      holdCheck(3'd3, bk, 4, "R7 read to auto-precharged bank held");
    end

    // Single-bank and all-bank precharge
    doReq(3'd2, 2'd0, 13'h0AA, 0, 0, t0);
    doReq(3'd2, 2'd1, 13'h055, 0, 0, t0);
    holdCheck(3'd2, 2'd1, 3, "R6 activate to open bank held");
    doReq(3'd5, 2'd0, 13'h1FFF, 0, 0, t0);
    pinCheck(P_PRE, 13'h0, 2'd0, 1, "R8 single precharge");
    holdCheck(3'd3, 2'd0, 3, "R8 read to precharged bank held");
    doReq(3'd3, 2'd1, 13'd9, 0, 0, t0);
    doReq(3'd5, 2'd3, 13'h0, 1, 0, t0);
    pinCheck(P_PRE, 13'h400, 2'd0, 1, "R8 all precharge");
    holdCheck(3'd4, 2'd1, 3, "R8 write after all precharge held");

    // Hidden precharge before a mode load
    doReq(3'd2, 2'd2, 13'h123, 0, 0, t0);
    doReq(3'd1, 2'd0, 13'h020, 0, 0, t1);
    chk(lastPreCyc > t0, "R9 precharge inserted", lastPreCyc, t0 + 1);
    chk(lastPreA10 == 1, "R9 precharge all", int'(lastPreA10), 1);
    chk(t1 - lastPreCyc == TRP, "R9 tRP", t1 - lastPreCyc, TRP);

    // Auto refresh
    doReq(3'd6, 2'd0, 13'h0, 0, 0, t0);
    pinCheck(P_REF, 13'h0, 2'd0, 1, "R10 auto refresh");
    doReq(3'd2, 2'd0, 13'h1, 0, 0, t1);
    chk(t1 - t0 == TRFC, "R10 tRFC", t1 - t0, TRFC);
    doReq(3'd5, 2'd0, 13'h0, 0, 0, t1);

    // Self refresh
    doReq(3'd7, 2'd0, 13'h0, 0, 0, t0);
    @(negedge clk);
    chk(pinCmd == P_REF && cke == 0, "R11 self refresh entry", int'({pinCmd, cke}), int'({P_REF, 1'b0}));
    holdCheck(3'd2, 2'd0, 4, "R11 held in self refresh");
    chk(cke == 0, "R11 cke stays low", int'(cke), 0);
    doReq(3'd0, 2'd0, 13'h0, 0, 0, t1);
    @(negedge clk);
    chk(cke == 1 && pinCmd == P_NOP, "R11 exit", int'({pinCmd, cke}), int'({P_NOP, 1'b1}));
    doReq(3'd2, 2'd3, 13'h2, 0, 0, t2);
    chk(t2 - t1 == TXSR, "R11 tXSR", t2 - t1, TXSR);

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule